// File: doc/BRIEF.md
# GPIO Bank Register File with Bit-Masked Write Window

This block holds the software-visible control state of one GPIO bank of four ports, each port eight pins wide. Every port has three writable 8-bit registers (pin-use select, output drive enable, output level) and one read-only input register. The input register shows the pad levels after a two-stage synchronizer. The register bits drive the bank's `pin_cfg`, `pin_oe` and `pin_out` vectors directly. Pin `8*p + n` belongs to port `p`, bit `n`.

A second address window, `UPPER_OFS` bytes above the plain one, repeats the same layout and applies bit-masked writes. Write-data bits 15:8 pick which pins of the addressed port change, and bits 7:0 give their new levels. Software can therefore flip one pin without a read-modify-write cycle and without a lock shared with other pin owners. To turn a pin into a driven output, software writes its level first and then sets its enable. Clearing the enable returns the pin to input.

The bus is a simple synchronous request interface with no back-pressure. A request is taken on every rising edge where `bus_req` is high. A write takes effect on that edge. Read data comes back exactly one cycle later, qualified by `bus_rvalid`. The requester must accept read data in that cycle, because the block has no ready input and holds nothing.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, the select, enable and output registers of all ports are zero, so `pin_cfg`, `pin_oe` and `pin_out` are all zero and `bus_rvalid` is low.
- R2: A plain write replaces all eight bits of the addressed register with `bus_wdata[7:0]`. Any read returns zero in bits 31:8.
- R3: A write to the masked window sets bit n of the register to `bus_wdata[n]` when `bus_wdata[8+n]` is 1. It leaves bit n unchanged when `bus_wdata[8+n]` is 0.
- R4: Byte address = group*0x10 + port*4, with groups select=0, enable=1, output=2, input=3. Register bit n of port p drives pin 8p+n.
- R5: The masked window starts at `UPPER_OFS` (default 0x80) and uses the same group/port layout. A read there returns the same register contents as the plain address.
- R6: A read of the input register accepted on the third rising edge after a pin change returns the new level. Reads accepted on the first or second edge return the old level. The masked window has no input copy, and that offset reads zero.
- R7: Writes to an input register offset in either window, and any access to an address outside both windows or not word aligned, change no state. Such reads return zero.
- R8: `bus_rvalid` is high for exactly the one cycle after each accepted read, and low at all other times.
- R9: Pin control outputs change only on a rising edge that accepts a write. A level written before its enable is already driven when the enable rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, taken every cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data; bits 15:8 are the mask in the masked window |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | DATA_W (32) | Read data |
| pin_in | input | PORTS*PIN_W (32) | Asynchronous pad input levels |
| pin_out | output | PORTS*PIN_W (32) | Output level per pin |
| pin_oe | output | PORTS*PIN_W (32) | Output drive enable per pin |
| pin_cfg | output | PORTS*PIN_W (32) | Pin used as GPIO when 1 |

## Verification
Plain writes use data with non-zero upper bits. This shows whether only bits 7:0 land, and whether readback clears bits 31:8. Masked writes are tried with a partial mask, an all-zero mask and a full mask with zero values. These three cases separate a correct merge from a plain overwrite, an ignored mask, or an inverted mask. Input reads are issued back to back right after a pin change, which pins the synchronizer depth to exactly two stages. Writes to the input offsets and to unmapped addresses, each followed by readback, show that those accesses touch nothing.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Register groups inside one window; the encoding is the address field value.
  typedef enum logic [1:0] {
    GRP_SEL = 2'd0,
    GRP_ENA = 2'd1,
    GRP_LVL = 2'd2,
    GRP_INP = 2'd3
  } grp_e;

  typedef struct packed {
    logic hit;     // aligned and inside a window
    logic masked;  // inside the bit-masked window
    grp_e grp;
  } dec_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PORTS     = 4,
  parameter int UPPER_OFS = 'h80
) (
  input  logic [ADDR_W-1:0]          addr,
  output dec_t                       dec,
  output logic [$clog2(PORTS)-1:0]   port_idx
);
  localparam int PIDX_W = $clog2(PORTS);
  localparam int SPAN   = 4 * PORTS * 4;  // four groups of PORTS words
  localparam logic [ADDR_W-1:0] UP_A   = ADDR_W'(UPPER_OFS);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SPAN);

  logic              in_plain, in_mask;
  logic [ADDR_W-1:0] rel;

  always_comb begin
    in_plain   = addr < SPAN_A;
    in_mask    = (addr >= UP_A) && (addr < UP_A + SPAN_A);
    rel        = in_mask ? (addr - UP_A) : addr;
    dec.hit    = (in_plain || in_mask) && (rel[1:0] == 2'b00);
    dec.masked = in_mask;
    dec.grp    = grp_e'(rel[PIDX_W+3:PIDX_W+2]);
    port_idx   = rel[PIDX_W+1:2];
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  grp_e         grp,
  input  logic         masked,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0] sel_q,
  output logic [W-1:0] ena_q,
  output logic [W-1:0] lvl_q
);
  logic [W-1:0] bit_en;
  logic [W-1:0] nval;

  // Plain writes enable every bit; masked writes take the upper field.
  assign bit_en = masked ? wdata[2*W-1:W] : {W{1'b1}};
  assign nval   = wdata[W-1:0];

  function automatic logic [W-1:0] merge(input logic [W-1:0] old,
                                         input logic [W-1:0] en,
                                         input logic [W-1:0] v);
    return (old & ~en) | (v & en);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ena_q <= '0;
      lvl_q <= '0;
    end else if (wr_en) begin
      case (grp)
        GRP_SEL: sel_q <= merge(sel_q, bit_en, nval);
        GRP_ENA: ena_q <= merge(ena_q, bit_en, nval);
        GRP_LVL: lvl_q <= merge(lvl_q, bit_en, nval);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int PORTS     = 4,   // power of two
  parameter int PIN_W     = 8,   // 2*PIN_W must fit in DATA_W
  parameter int UPPER_OFS = 'h80 // at or above the plain window, word aligned
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic                     bus_rvalid,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [PORTS*PIN_W-1:0]   pin_in,
  output logic [PORTS*PIN_W-1:0]   pin_out,
  output logic [PORTS*PIN_W-1:0]   pin_oe,
  output logic [PORTS*PIN_W-1:0]   pin_cfg
);
  localparam int NPINS  = PORTS * PIN_W;
  localparam int PIDX_W = $clog2(PORTS);

  dec_t              dec;
  logic [PIDX_W-1:0] port_idx;
  logic [NPINS-1:0]  in_sync;
  logic              wr_ok;
  logic [PIN_W-1:0]  sel_a [PORTS];
  logic [PIN_W-1:0]  ena_a [PORTS];
  logic [PIN_W-1:0]  lvl_a [PORTS];
  logic [PIN_W-1:0]  inp_a [PORTS];
  logic [PIN_W-1:0]  rd_val;

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .PORTS(PORTS), .UPPER_OFS(UPPER_OFS)
  ) u_dec (
    .addr(bus_addr), .dec(dec), .port_idx(port_idx)
  );

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
  );

  assign wr_ok = bus_req && bus_we && dec.hit && (dec.grp != GRP_INP);

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_port_regs #(.W(PIN_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_ok && (port_idx == PIDX_W'(p))),
      .grp   (dec.grp),
      .masked(dec.masked),
      .wdata (bus_wdata[2*PIN_W-1:0]),
      .sel_q (sel_a[p]),
      .ena_q (ena_a[p]),
      .lvl_q (lvl_a[p])
    );
    assign inp_a[p]                    = in_sync[p*PIN_W +: PIN_W];
    assign pin_cfg[p*PIN_W +: PIN_W]   = sel_a[p];
    assign pin_oe[p*PIN_W +: PIN_W]    = ena_a[p];
    assign pin_out[p*PIN_W +: PIN_W]   = lvl_a[p];
  end

  always_comb begin
    rd_val = '0;
    if (dec.hit) begin
      case (dec.grp)
        GRP_SEL: rd_val = sel_a[port_idx];
        GRP_ENA: rd_val = ena_a[port_idx];
        GRP_LVL: rd_val = lvl_a[port_idx];
        GRP_INP: rd_val = dec.masked ? '0 : inp_a[port_idx];
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we)
        bus_rdata <= {{(DATA_W-PIN_W){1'b0}}, rd_val};
    end
  end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int PORTS     = 4,
  parameter int PIN_W     = 8,
  parameter int UPPER_OFS = 'h80
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_req,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DATA_W-1:0]      bus_wdata,
  input logic                   bus_rvalid,
  input logic [DATA_W-1:0]      bus_rdata,
  input logic [PORTS*PIN_W-1:0] pin_out,
  input logic [PORTS*PIN_W-1:0] pin_oe,
  input logic [PORTS*PIN_W-1:0] pin_cfg
);
  localparam logic [ADDR_W-1:0] A_SEL0   = '0;
  localparam logic [ADDR_W-1:0] A_LVL0_M = ADDR_W'(UPPER_OFS + 2*PORTS*4);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'({PIN_W{1'b1}});

  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_we)); // R8
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid); // R8
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> (bus_rdata & ~LOW_MASK) == '0); // R2
  AST_PLAIN_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == A_SEL0)
      |=> DATA_W'(pin_cfg[PIN_W-1:0]) == ($past(bus_wdata) & LOW_MASK)); // R2
  AST_MASK_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == A_LVL0_M)
      |=> ((pin_out[PIN_W-1:0] ^ $past(pin_out[PIN_W-1:0]))
           & ~$past(bus_wdata[2*PIN_W-1:PIN_W])) == '0); // R3
  AST_PINS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_cfg))); // R9
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORTS(PORTS), .PIN_W(PIN_W), .UPPER_OFS(UPPER_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_cfg(pin_cfg)
);

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;
  localparam int UP = 'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pin_cfg;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  gpio_bank_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_cfg(pin_cfg)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at the falling edge after acceptance.
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  // Monitor: pops one expected item per returned read.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R8: unexpected read data %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pins", pin_out | pin_oe | pin_cfg, 32'h0);
    check("R1 reset rvalid", {31'b0, bus_rvalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(12'h000, 32'h0, "R1 select port0 after reset");
    bus_read(12'h014, 32'h0, "R1 enable port1 after reset");

    // Plain write: only the low byte lands (R2), mapped to pins 7:0 (R4)
    bus_write(12'h000, 32'hDEAD_BEA5);
    check("R4 pin_cfg port0", pin_cfg, 32'h0000_00A5);
    check("R8 rvalid low after write", {31'b0, bus_rvalid}, 32'h0);
    bus_read(12'h000, 32'h0000_00A5, "R2 plain readback");
    bus_write(12'h018, 32'h0000_003C);
    check("R4 pin_oe port2", pin_oe, 32'h003C_0000);

    // Masked window merges (R3) and mirrors readback (R5)
    bus_write(12'h024, 32'h0000_00F0);
    bus_write(12'(UP + 'h24), 32'h0000_0F05);
    check("R3 partial mask", pin_out, 32'h0000_F500);
    bus_read(12'(UP + 'h24), 32'h0000_00F5, "R5 masked window readback");
    bus_read(12'h024, 32'h0000_00F5, "R5 plain view of same reg");
    bus_write(12'(UP + 'h24), 32'h0000_00FF);
    check("R3 zero mask keeps", pin_out, 32'h0000_F500);
    bus_write(12'(UP + 'h24), 32'h0000_FF00);
    check("R3 full mask clears", pin_out, 32'h0);

    // Level before enable on pin 31 (R9)
    bus_write(12'(UP + 'h2C), 32'h0000_8080);
    check("R9 level before enable", pin_out, 32'h8000_0000);
    bus_write(12'(UP + 'h1C), 32'h0000_8080);
    check("R9 enable pin31", pin_oe, 32'h803C_0000);
    check("R9 level held at enable", pin_out, 32'h8000_0000);

    // Input synchronizer latency (R6)
    pin_in = 32'h1234_5678;
    bus_read(12'h030, 32'h0, "R6 first edge old");
    bus_read(12'h030, 32'h0, "R6 second edge old");
    bus_read(12'h030, 32'h0000_0078, "R6 third edge new");
    bus_read(12'h03C, 32'h0000_0012, "R6 port3 input");
    bus_read(12'(UP + 'h30), 32'h0, "R6 no masked input copy");

    // Ignored accesses (R7)
    bus_write(12'h030, 32'h0000_00FF);
    bus_write(12'(UP + 'h38), 32'h0000_FFFF);
    bus_read(12'h038, 32'h0000_0034, "R7 input unaffected by write");
    bus_write(12'h040, 32'h0000_00FF);
    bus_write(12'h001, 32'h0000_0000);
    bus_write(12'h0C4, 32'h0000_FFFF);
    check("R7 pin_cfg unchanged", pin_cfg, 32'h0000_00A5);
    check("R7 pin_oe unchanged", pin_oe, 32'h803C_0000);
    check("R7 pin_out unchanged", pin_out, 32'h8000_0000);
    bus_read(12'h040, 32'h0, "R7 unmapped read zero");
    bus_read(12'h002, 32'h0, "R7 unaligned read zero");

    repeat (3) @(negedge clk);
    check("R8 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule